// File: doc/BRIEF.md
# Dual-Table Quantizing Huffman Encoder

The encoder turns a block of 64 sixteen-bit symbols into a packed variable-length bitstream. Two programmable code tables are held inside: a normal table used when the block is coded without loss, and a quantized table used when the block is coded with approximation. In the approximate mode the lower half of every 32-bit word (the first symbol of each pair) has a selectable number of least-significant bits forced to zero before lookup. That quantization covers the whole block evenly. No individual symbols are picked out for truncation. A symbol that finds no entry in the active table is sent as a fixed escape code followed by the raw 16-bit lookup key.

A block starts with a one-cycle `start` pulse that picks the mode and quantization depth. After that, one symbol is taken on each cycle in which `sym_valid` is high. The block is split into four segments of 16 symbols so that a decoder can work on them in parallel. The 22-bit header at the front of the stream carries a mode flag and the byte offsets of segments two to four. Segments two to four are padded to a byte boundary so that 7-bit pointers can address a 128-byte stream. When the 64th symbol has been taken, `done` pulses. The stream, the header and the total bit count then stay on the outputs until the next block begins. Table entries are written one at a time through a small write port.

Top module: `qhuff_enc`

## Requirements
- R1: After reset `busy`, `done`, `bit_count`, `header` and `bits_out` are all zero, and every table entry is invalid.
- R2: In lossless mode (`lossy`=0, mode flag 0) a symbol that equals the key of a valid normal-table entry is coded as the low `len` bits of that entry's codeword, most significant of those bits first. Codeword bits above `len` are never emitted. Stream bit 0 is the first bit sent, and bits fill toward higher indices with no gaps inside a segment. In lossless mode `q_sel` has no effect.
- R3: A lookup key that matches no valid entry of the active table is coded as 21 bits: the escape code 5'b11111 and then the 16-bit key, each sent most significant bit first.
- R4: In lossy mode (`lossy`=1, mode flag 1) the symbols with even index (0, 2, 4, …; the lower half of each 32-bit word) have their low 4×(`q_sel`+1) bits cleared before lookup. Odd-index symbols are looked up unchanged. All keys are looked up only in the quantized table (`tbl_sel`=1).
- R5: With `q_sel`=3 in lossy mode every even-index key becomes 0x0000 and is still looked up, so it matches a quantized entry whose key is zero.
- R6: Header bit 0 is the mode flag. The pointers to segments 2, 3 and 4 occupy bits 1–7, 8–14 and 15–21, each least significant bit first. The mode flag does not change while a block is in progress.
- R7: Segment 1 (symbols 0–15) starts at bit 22. Before symbols 16, 32 and 48, the stream is padded with zero bits up to the next multiple of 8. The matching pointer holds that start position divided by 8, modulo 128.
- R8: A symbol is taken on each busy cycle with `sym_valid` high. On the clock edge that takes symbol 63, `busy` falls and `done` rises for exactly one cycle. `bit_count` then gives the total stream length, including header and padding, and it never decreases during a block.
- R9: Stream bits at positions 1024 and above are discarded, while `bit_count` still reports the full length.
- R10: `start` is ignored while `busy` is high. `sym_valid` is ignored while idle. Between blocks the stream, header and count do not change.
- R11: A table write with `tbl_len`=0 makes that entry invalid, so it no longer matches. A write with `tbl_len` of 1 to 16 makes the entry valid. If keys are duplicated, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | Table chosen for the write: 0 normal, 1 quantized |
| tbl_idx | input | 4 | Entry index to write |
| tbl_key | input | 16 | Symbol key of the entry |
| tbl_cw | input | 16 | Codeword, right aligned |
| tbl_len | input | 5 | Codeword length, 0 marks the entry invalid |
| start | input | 1 | Begin a block (taken only when idle) |
| lossy | input | 1 | Mode for the block: 1 quantized table |
| q_sel | input | 2 | Quantized low bits: 4×(q_sel+1) |
| sym_valid | input | 1 | A symbol is presented |
| sym_data | input | 16 | Symbol value |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle pulse when the block completes |
| bit_count | output | 11 | Total stream length in bits |
| header | output | 22 | Mode flag and segment pointers |
| bits_out | output | 1024 | Packed stream, bit 0 first |

## Verification
The assertions check every cycle that `done` lasts a single cycle and arrives only as `busy` falls. They also check that the bit count grows monotonically and the mode flag holds steady during a block, that an idle encoder keeps its results, and that a finished block is at least as long as its header. The exact bit placement cannot be seen by a per-cycle property. This covers codeword order, escape layout, quantization of the lower half-word for each depth, segment padding, pointer values and the discarding of bits past 1024. The bench shows these by sweeping both modes across all four depths and rebuilding the expected stream bit by bit.

// File: rtl/qhuff_pkg.sv
package qhuff_pkg;
    localparam int SYM_W     = 16;
    localparam int CW_MAX    = 16;
    localparam int LEN_W     = 5;
    localparam int ESC_LEN   = 5;
    localparam logic [ESC_LEN-1:0] ESC_CW = '1;
    localparam int CH_W      = ESC_LEN + SYM_W;
    localparam int QSTEP     = 4;
    localparam int ENTRIES   = 16;
    localparam int TIDX_W    = $clog2(ENTRIES);
    localparam int SYMS      = 64;
    localparam int SEGS      = 4;
    localparam int SEG_LEN   = SYMS / SEGS;
    localparam int SEG_SH    = $clog2(SEG_LEN);
    localparam int IDX_W     = $clog2(SYMS);
    localparam int BLK_BYTES = SYMS * SYM_W / 8;
    localparam int PTR_W     = $clog2(BLK_BYTES);
    localparam int HDR_W     = 1 + (SEGS - 1) * PTR_W;
    localparam int BUF_W     = 1024;
    localparam int POS_W     = $clog2(HDR_W + SYMS * CH_W + SEGS * 8 + 1);

    typedef struct packed {
        logic [SYM_W-1:0]  key;
        logic [CW_MAX-1:0] cw;
        logic [LEN_W-1:0]  len;
    } entry_t;

    // Bits kept after quantization: the low QSTEP*(q+1) bits are cleared.
    function automatic logic [SYM_W-1:0] keep_mask(input logic [1:0] q);
        logic [SYM_W-1:0] m;
        for (int b = 0; b < SYM_W; b++) begin
            m[b] = (b >= QSTEP * (int'(q) + 1));
        end
        return m;
    endfunction
endpackage

// File: rtl/qhuff_table.sv
module qhuff_table
    import qhuff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [TIDX_W-1:0] widx,
    input  entry_t            wentry,
    input  logic [SYM_W-1:0]  key,
    output logic              hit,
    output logic [CW_MAX-1:0] cw,
    output logic [LEN_W-1:0]  len
);
    entry_t ent_q [ENTRIES];
    entry_t ent_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = (we && widx == TIDX_W'(i)) ? wentry : ent_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) ent_q[i] <= ent_d[i];
        end
    end

    // Associative match; scanning downward lets the lowest index win.
    always_comb begin
        hit = 1'b0;
        cw  = '0;
        len = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ent_q[i].len != '0 && ent_q[i].key == key) begin
                hit = 1'b1;
                cw  = ent_q[i].cw;
                len = ent_q[i].len;
            end
        end
    end
endmodule

// File: rtl/qhuff_chunk.sv
module qhuff_chunk
    import qhuff_pkg::*;
(
    input  logic              hit,
    input  logic [CW_MAX-1:0] cw,
    input  logic [LEN_W-1:0]  len,
    input  logic [SYM_W-1:0]  key,
    output logic [CH_W-1:0]   bits,
    output logic [LEN_W-1:0]  nbits
);
    logic [CW_MAX-1:0] sh;
    logic [CH_W-1:0]   esc;

    // bits[i] is the i-th bit sent; unused positions stay zero.
    always_comb begin
        sh   = cw << (LEN_W'(CW_MAX) - len);
        esc  = {ESC_CW, key};
        bits = '0;
        if (hit) begin
            for (int i = 0; i < CW_MAX; i++) bits[i] = sh[CW_MAX-1-i];
            nbits = len;
        end else begin
            for (int i = 0; i < CH_W; i++) bits[i] = esc[CH_W-1-i];
            nbits = LEN_W'(CH_W);
        end
    end
endmodule

// File: rtl/qhuff_enc.sv
module qhuff_enc
    import qhuff_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic              tbl_sel,
    input  logic [TIDX_W-1:0] tbl_idx,
    input  logic [SYM_W-1:0]  tbl_key,
    input  logic [CW_MAX-1:0] tbl_cw,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic              start,
    input  logic              lossy,
    input  logic [1:0]        q_sel,
    input  logic              sym_valid,
    input  logic [SYM_W-1:0]  sym_data,
    output logic              busy,
    output logic              done,
    output logic [POS_W-1:0]  bit_count,
    output logic [HDR_W-1:0]  header,
    output logic [BUF_W-1:0]  bits_out
);
    typedef struct packed {
        logic             busy;
        logic             lossy;
        logic [SYM_W-1:0] keep;
        logic [IDX_W-1:0] idx;
        logic [POS_W-1:0] pos;
        logic             done;
        logic [BUF_W-1:0] sbuf;
    } state_t;

    state_t s_q, s_d;

    entry_t            wentry;
    logic [SYM_W-1:0]  key;
    logic              n_hit, q_hit, hit;
    logic [CW_MAX-1:0] n_cw, q_cw, cw;
    logic [LEN_W-1:0]  n_len, q_len, len;
    logic [CH_W-1:0]   ch_bits;
    logic [LEN_W-1:0]  ch_n;
    logic              seg_edge;
    logic [IDX_W-1:0]  seg_num;
    logic [POS_W-1:0]  pos_al;

    assign wentry = '{key: tbl_key, cw: tbl_cw, len: tbl_len};
    assign key    = sym_data & ((s_q.lossy && !s_q.idx[0]) ? s_q.keep : '1);

    qhuff_table u_norm (
        .clk(clk), .rst_n(rst_n), .we(tbl_we && !tbl_sel), .widx(tbl_idx),
        .wentry(wentry), .key(key), .hit(n_hit), .cw(n_cw), .len(n_len)
    );

    qhuff_table u_quant (
        .clk(clk), .rst_n(rst_n), .we(tbl_we && tbl_sel), .widx(tbl_idx),
        .wentry(wentry), .key(key), .hit(q_hit), .cw(q_cw), .len(q_len)
    );

    assign hit = s_q.lossy ? q_hit : n_hit;
    assign cw  = s_q.lossy ? q_cw  : n_cw;
    assign len = s_q.lossy ? q_len : n_len;

    qhuff_chunk u_chunk (
        .hit(hit), .cw(cw), .len(len), .key(key), .bits(ch_bits), .nbits(ch_n)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        seg_num  = s_q.idx >> SEG_SH;
        seg_edge = (s_q.idx[SEG_SH-1:0] == '0) && (s_q.idx != '0);
        pos_al   = seg_edge ? ((s_q.pos + POS_W'(7)) & ~POS_W'(7)) : s_q.pos;

        if (!s_q.busy) begin
            if (start) begin
                s_d.busy    = 1'b1;
                s_d.lossy   = lossy;
                s_d.keep    = keep_mask(q_sel);
                s_d.idx     = '0;
                s_d.pos     = POS_W'(HDR_W);
                s_d.sbuf    = '0;
                s_d.sbuf[0] = lossy;
            end
        end else if (sym_valid) begin
            if (seg_edge) begin
                for (int k = 0; k < SEGS - 1; k++) begin
                    if (seg_num == IDX_W'(k + 1)) begin
                        s_d.sbuf[1 + k*PTR_W +: PTR_W] = PTR_W'(pos_al >> 3);
                    end
                end
            end
            s_d.sbuf = s_d.sbuf | (BUF_W'(ch_bits) << pos_al);
            s_d.pos  = pos_al + POS_W'(ch_n);
            s_d.idx  = s_q.idx + IDX_W'(1);
            if (s_q.idx == IDX_W'(SYMS - 1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign bit_count = s_q.pos;
    assign header    = s_q.sbuf[HDR_W-1:0];
    assign bits_out  = s_q.sbuf;
endmodule

// File: rtl/qhuff_enc_chk.sv
module qhuff_enc_chk
    import qhuff_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [POS_W-1:0] bit_count,
    input logic             mode_bit
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_count_grows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> bit_count >= $past(bit_count));

    assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(mode_bit));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !$past(busy) && !$past(start) |-> $stable(bit_count) && $stable(mode_bit));

    assert_hdr_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bit_count >= POS_W'(HDR_W));
endmodule

bind qhuff_enc qhuff_enc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .bit_count(bit_count), .mode_bit(bits_out[0])
);

// File: tb/sim_qhuff_enc.sv
module sim_qhuff_enc;
    import qhuff_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0, tbl_sel = 1'b0;
    logic [TIDX_W-1:0] tbl_idx = '0;
    logic [SYM_W-1:0] tbl_key = '0;
    logic [CW_MAX-1:0] tbl_cw = '0;
    logic [LEN_W-1:0] tbl_len = '0;
    logic start = 1'b0, lossy = 1'b0;
    logic [1:0] q_sel = '0;
    logic sym_valid = 1'b0;
    logic [SYM_W-1:0] sym_data = '0;
    logic busy, done;
    logic [POS_W-1:0] bit_count;
    logic [HDR_W-1:0] header;
    logic [BUF_W-1:0] bits_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    qhuff_enc u0 (.*);

    int checks = 0, fails = 0;
    logic [15:0] tkey [2][16];
    logic [15:0] tcw  [2][16];
    int          tlen [2][16];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_stream(input string req, input logic [BUF_W-1:0] exp);
        int first = -1;
        for (int p = BUF_W - 1; p >= 0; p--) if (bits_out[p] !== exp[p]) first = p;
        checks++;
        if (first >= 0) begin
            fails++;
            $display("FAIL %s stream bit %0d: actual %b expected %b",
                     req, first, bits_out[first], exp[first]);
        end
    endtask

    task automatic wr(input int sel, input int idx, input logic [15:0] key,
                      input logic [15:0] cw, input int len);
        @(negedge clk);
        tbl_we = 1'b1; tbl_sel = sel[0]; tbl_idx = TIDX_W'(idx);
        tbl_key = key; tbl_cw = cw; tbl_len = LEN_W'(len);
        tkey[sel][idx] = key; tcw[sel][idx] = cw; tlen[sel][idx] = len;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    function automatic logic [15:0] gen(int j, int seed, int kind);
        int r = (j + seed) % 16;
        if (kind == 1) return 16'h0F0F + 16'(j);
        if (kind == 2) return 16'h1234 + 16'(j * 16'h0101);
        case (j % 4)
            0: return tkey[0][r];
            1: return 16'(r << 12) | 16'(j % 16);
            2: return 16'(j * 40503 + seed * 4660 + 1);
            default: return tkey[0][(r + 5) % 16] ^ ((j % 3 == 0) ? 16'h0001 : 16'h0000);
        endcase
    endfunction

    // Expected stream built from the requirements (R2-R7, R9).
    task automatic model(input bit md, input int q, input int seed, input int kind,
                         output logic [BUF_W-1:0] eb, output int ecnt);
        int pos = HDR_W;
        int t = md ? 1 : 0;
        eb = '0;
        eb[0] = md;
        for (int j = 0; j < SYMS; j++) begin
            logic [15:0] sym = gen(j, seed, kind);
            logic [15:0] key = sym;
            int hi = -1;
            if (md && (j % 2 == 0)) key = sym & ~16'((1 << (4 * (q + 1))) - 1);
            if (j % 16 == 0 && j != 0) begin
                int p;
                pos = (pos + 7) / 8 * 8;
                p = (pos / 8) % 128;
                for (int b = 0; b < 7; b++) eb[1 + 7 * (j / 16 - 1) + b] = p[b];
            end
            for (int i = 15; i >= 0; i--)
                if (tlen[t][i] != 0 && tkey[t][i] == key) hi = i;
            if (hi >= 0) begin
                int l = tlen[t][hi];
                for (int b = 0; b < l; b++)
                    if (pos + b < BUF_W) eb[pos + b] = tcw[t][hi][l - 1 - b];
                pos += l;
            end else begin
                logic [20:0] full = {5'h1F, key};
                for (int b = 0; b < 21; b++)
                    if (pos + b < BUF_W) eb[pos + b] = full[20 - b];
                pos += 21;
            end
        end
        ecnt = pos;
    endtask

    task automatic run_block(input bit md, input int q, input int seed, input int kind,
                             input bit poke, input string req);
        logic [BUF_W-1:0] eb;
        int ecnt;
        model(md, q, seed, kind, eb, ecnt);
        @(negedge clk);
        start = 1'b1; lossy = md; q_sel = 2'(q);
        @(negedge clk);
        start = 1'b0;
        for (int j = 0; j < SYMS; j++) begin
            sym_valid = 1'b1;
            sym_data = gen(j, seed, kind);
            // R10: a second start mid-block must be ignored
            if (poke && j == 20) begin start = 1'b1; lossy = ~md; q_sel = 2'(q + 1); end
            else start = 1'b0;
            @(negedge clk);
        end
        sym_valid = 1'b0;
        start = 1'b0;
        check(done === 1'b1, "R8", "done at block end", longint'(done), 1);
        check(busy === 1'b0, "R8", "busy at block end", longint'(busy), 0);
        check(int'(bit_count) == ecnt, req, "bit_count", longint'(bit_count), ecnt);
        check_stream(req, eb);
        check(header === eb[HDR_W-1:0], "R6", "header", longint'(header), longint'(eb[HDR_W-1:0]));
        check(header[7:1] === eb[7:1], "R7", "segment 2 pointer", longint'(header[7:1]), longint'(eb[7:1]));
        @(negedge clk);
        check(done === 1'b0, "R8", "done pulse width", longint'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [BUF_W-1:0] keep_bits;
        logic [POS_W-1:0] keep_cnt;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0, "R1", "busy", longint'(busy), 0);
        check(done === 1'b0, "R1", "done", longint'(done), 0);
        check(bit_count === '0, "R1", "bit_count", longint'(bit_count), 0);
        check(bits_out === '0, "R1", "bits_out", longint'(bits_out[63:0]), 0);
        rst_n = 1'b1;

        // R11: table loading
        for (int i = 0; i < 16; i++) begin
            wr(0, i, 16'hA000 ^ 16'(i * 16'h0111), 16'(i * 16'h03A5 + 16'h5A3C),
               (i == 15) ? 16 : 2 + (i % 7));
            wr(1, i, 16'(i << 12), 16'(i * 16'h01F1 + 16'h00C3),
               (i == 0) ? 1 : 3 + (i % 6));
        end

        // R2 / R4: both modes across every quantization depth
        for (int md = 0; md < 2; md++)
            for (int q = 0; q < 4; q++)
                run_block(md[0], q, q + 7 * md, 0, 1'b0, md ? "R4" : "R2");

        // R5: full-width quantization folds even symbols to zero
        run_block(1'b1, 3, 0, 2, 1'b0, "R5");
        // R3 and R9: all escapes, stream longer than capacity
        run_block(1'b0, 0, 0, 1, 1'b0, "R3");
        check(int'(bit_count) > BUF_W, "R9", "count beyond capacity", longint'(bit_count), BUF_W + 1);
        run_block(1'b0, 2, 3, 1, 1'b0, "R9");

        // R10: start ignored while busy, sym_valid ignored while idle
        run_block(1'b0, 1, 5, 0, 1'b1, "R10");
        keep_bits = bits_out;
        keep_cnt = bit_count;
        for (int k = 0; k < 5; k++) begin
            sym_valid = 1'b1;
            sym_data = 16'(k * 16'h1357);
            @(negedge clk);
        end
        sym_valid = 1'b0;
        check(bit_count === keep_cnt, "R10", "idle count", longint'(bit_count), longint'(keep_cnt));
        check(bits_out === keep_bits, "R10", "idle stream", longint'(bits_out[63:0]), longint'(keep_bits[63:0]));
        check(busy === 1'b0, "R10", "idle busy", longint'(busy), 0);

        // R11: invalidated entries no longer match
        wr(0, 0, tkey[0][0], tcw[0][0], 0);
        wr(0, 3, tkey[0][3], tcw[0][3], 0);
        run_block(1'b0, 0, 0, 0, 1'b0, "R11");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule